// File: doc/BRIEF.md
# Two-Bit Branch Predictor Table with Stored Targets

This block is a small direct-mapped table that guesses the direction of a branch while the branch is being decoded. Each slot pairs a two-bit saturating history counter with the address the branch jumped to the last time it was taken. The fetch side presents the branch's address on the lookup port. The table then returns a taken hint, the stored jump address and the next fetch address. That address is the stored one when the hint says taken, and the sequential successor when it does not.

When the branch resolves, the execute side drives the update port with the slot index, the real outcome and the resolved jump address. A taken outcome moves the counter up and rewrites the stored address. A not-taken outcome moves the counter down. Only the counter's upper half predicts taken. With a correct taken guess the branch costs one bubble instead of three. With a correct not-taken guess it costs none instead of two.

Top module: `branch_hint_table`

## Requirements
- R1: After reset every counter holds 00 and every stored address is zero, so every lookup gives lk_taken = 0, lk_target = 0 and lk_next_pc = lk_pc + SEQ_STEP.
- R2: The lookup slot is lk_pc bits [INDEX_LSB+IDX_W-1 : INDEX_LSB]. Two addresses that agree in these bits read the same slot, whatever their other bits hold.
- R3: An update with up_valid = 1 and up_taken = 1 raises the slot's counter by one. At 11 the counter stays at 11.
- R4: An update with up_valid = 1 and up_taken = 0 lowers the slot's counter by one. At 00 the counter stays at 00.
- R5: lk_taken is 1 exactly when the looked-up counter is 10 or 11.
- R6: lk_next_pc equals lk_target when lk_taken is 1, and lk_pc + SEQ_STEP otherwise.
- R7: A taken update writes up_target into the slot's stored address. A not-taken update leaves every stored address unchanged. lk_target always shows the slot's stored address.
- R8: An update takes effect at the clock edge that samples it. A lookup in the same cycle, to the same slot, sees the contents from before the update.
- R9: While up_valid = 0, no counter and no stored address changes.
- R10: An update changes only the slot named by up_index. Every other slot keeps its counter and its address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_pc | input | ADDR_W | Address of the branch being decoded |
| lk_taken | output | 1 | Taken hint for lk_pc |
| lk_target | output | ADDR_W | Stored jump address of the selected slot |
| lk_next_pc | output | ADDR_W | Predicted next fetch address |
| up_valid | input | 1 | A resolved branch is presented this cycle |
| up_index | input | IDX_W | Slot written by the update |
| up_taken | input | 1 | Resolved direction (1 = taken) |
| up_target | input | ADDR_W | Resolved jump address |

## Verification
The bound checker watches every cycle for the following:
- each counter step on the updated slot, including both saturation ends;
- the stored address being written on a taken update and held on a not-taken one;
- the whole table staying frozen while no update is valid;
- the taken hint and next-address selection agreeing with the selected counter.

Some behaviours only the bench scenarios show, because they need a history of updates and lookups compared against an independent model. These are the reset contents, the aliasing of addresses that share index bits, the isolation of neighbouring slots, and the old-contents result of a lookup that collides with an update.

// File: rtl/bht_pkg.sv
package bht_pkg;

   typedef logic [1:0] hist_t;

   localparam hist_t HIST_INIT = 2'b00;
   localparam hist_t HIST_MAX  = 2'b11;
   localparam hist_t HIST_MIN  = 2'b00;

   // Saturating step of a history counter for one resolved outcome.
   function automatic hist_t hist_step(input hist_t cur, input logic taken);
      hist_t nxt;
      if (taken) begin
         nxt = (cur == HIST_MAX) ? HIST_MAX : cur + 2'd1;
      end else begin
         nxt = (cur == HIST_MIN) ? HIST_MIN : cur - 2'd1;
      end
      return nxt;
   endfunction

   // Upper half of the counter range predicts taken.
   function automatic logic hist_says_taken(input hist_t cur);
      return cur[1];
   endfunction

endpackage

// File: rtl/bht_hist_bank.sv
module bht_hist_bank
   import bht_pkg::*;
#(
   parameter int DEPTH = 16,
   localparam int IDX_W = $clog2(DEPTH)
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [IDX_W-1:0]   wr_idx,
   input  logic               wr_taken,
   output logic [DEPTH*2-1:0] hist_flat
);

   generate
      for (genvar g = 0; g < DEPTH; g++) begin : g_slot
         hist_t cnt_q;
         logic  sel;

         assign sel = wr_en && (wr_idx == IDX_W'(g));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= HIST_INIT;
            end else if (sel) begin
               cnt_q <= hist_step(cnt_q, wr_taken);
            end
         end

         assign hist_flat[g*2 +: 2] = cnt_q;
      end
   endgenerate

endmodule

// File: rtl/bht_target_bank.sv
module bht_target_bank #(
   parameter int DEPTH  = 16,
   parameter int ADDR_W = 32,
   localparam int IDX_W = $clog2(DEPTH)
)(
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic [IDX_W-1:0]        wr_idx,
   input  logic [ADDR_W-1:0]       wr_data,
   output logic [DEPTH*ADDR_W-1:0] tgt_flat
);

   generate
      for (genvar g = 0; g < DEPTH; g++) begin : g_slot
         logic [ADDR_W-1:0] tgt_q;
         logic              sel;

         assign sel = wr_en && (wr_idx == IDX_W'(g));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               tgt_q <= '0;
            end else if (sel) begin
               tgt_q <= wr_data;
            end
         end

         assign tgt_flat[g*ADDR_W +: ADDR_W] = tgt_q;
      end
   endgenerate

endmodule

// File: rtl/bht_read_port.sv
module bht_read_port
   import bht_pkg::*;
#(
   parameter int DEPTH     = 16,
   parameter int ADDR_W    = 32,
   parameter int INDEX_LSB = 2,
   parameter int SEQ_STEP  = 4,
   localparam int IDX_W    = $clog2(DEPTH)
)(
   input  logic [ADDR_W-1:0]       pc,
   input  logic [DEPTH*2-1:0]      hist_flat,
   input  logic [DEPTH*ADDR_W-1:0] tgt_flat,
   output logic                    taken,
   output logic [ADDR_W-1:0]       target,
   output logic [ADDR_W-1:0]       next_pc
);

   logic [IDX_W-1:0]  rd_idx;
   hist_t             rd_hist;
   logic [ADDR_W-1:0] seq_pc;

   assign rd_idx  = pc[INDEX_LSB +: IDX_W];
   assign rd_hist = hist_flat[rd_idx*2 +: 2];
   assign target  = tgt_flat[rd_idx*ADDR_W +: ADDR_W];
   assign taken   = hist_says_taken(rd_hist);
   assign seq_pc  = pc + ADDR_W'(SEQ_STEP);

   always_comb begin
      if (taken) begin
         next_pc = target;
      end else begin
         next_pc = seq_pc;
      end
   end

endmodule

// File: rtl/branch_hint_table.sv
module branch_hint_table #(
   parameter int DEPTH     = 16,
   parameter int ADDR_W    = 32,
   parameter int INDEX_LSB = 2,
   parameter int SEQ_STEP  = 4,
   localparam int IDX_W    = $clog2(DEPTH)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] lk_pc,
   output logic              lk_taken,
   output logic [ADDR_W-1:0] lk_target,
   output logic [ADDR_W-1:0] lk_next_pc,
   input  logic              up_valid,
   input  logic [IDX_W-1:0]  up_index,
   input  logic              up_taken,
   input  logic [ADDR_W-1:0] up_target
);

   initial begin
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0)
         $error("DEPTH must be a power of two of at least 2");
      if (ADDR_W < INDEX_LSB + IDX_W)
         $error("ADDR_W too small for the index field");
      if (SEQ_STEP < 1)
         $error("SEQ_STEP must be positive");
   end

   logic [DEPTH*2-1:0]      hist_flat;
   logic [DEPTH*ADDR_W-1:0] tgt_flat;
   logic                    tgt_wr;

   assign tgt_wr = up_valid && up_taken;

   bht_hist_bank #(
      .DEPTH (DEPTH)
   ) u_hist (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (up_valid),
      .wr_idx    (up_index),
      .wr_taken  (up_taken),
      .hist_flat (hist_flat)
   );

   bht_target_bank #(
      .DEPTH  (DEPTH),
      .ADDR_W (ADDR_W)
   ) u_tgt (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (tgt_wr),
      .wr_idx   (up_index),
      .wr_data  (up_target),
      .tgt_flat (tgt_flat)
   );

   bht_read_port #(
      .DEPTH     (DEPTH),
      .ADDR_W    (ADDR_W),
      .INDEX_LSB (INDEX_LSB),
      .SEQ_STEP  (SEQ_STEP)
   ) u_rd (
      .pc        (lk_pc),
      .hist_flat (hist_flat),
      .tgt_flat  (tgt_flat),
      .taken     (lk_taken),
      .target    (lk_target),
      .next_pc   (lk_next_pc)
   );

endmodule

// File: rtl/bht_checker.sv
module bht_checker #(
   parameter int DEPTH     = 16,
   parameter int ADDR_W    = 32,
   parameter int INDEX_LSB = 2,
   parameter int SEQ_STEP  = 4,
   localparam int IDX_W    = $clog2(DEPTH)
)(
   input logic                    clk,
   input logic                    rst_n,
   input logic [ADDR_W-1:0]       lk_pc,
   input logic                    lk_taken,
   input logic [ADDR_W-1:0]       lk_target,
   input logic [ADDR_W-1:0]       lk_next_pc,
   input logic                    up_valid,
   input logic [IDX_W-1:0]        up_index,
   input logic                    up_taken,
   input logic [ADDR_W-1:0]       up_target,
   input logic [DEPTH*2-1:0]      hist_flat,
   input logic [DEPTH*ADDR_W-1:0] tgt_flat
);

   function automatic logic [1:0] hist_at(input logic [DEPTH*2-1:0] v,
                                          input logic [IDX_W-1:0] i);
      return v[i*2 +: 2];
   endfunction

   function automatic logic [ADDR_W-1:0] tgt_at(input logic [DEPTH*ADDR_W-1:0] v,
                                                input logic [IDX_W-1:0] i);
      return v[i*ADDR_W +: ADDR_W];
   endfunction

   logic [IDX_W-1:0] lk_idx;
   assign lk_idx = lk_pc[INDEX_LSB +: IDX_W];

   p_inc_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (up_valid && up_taken && hist_at(hist_flat, up_index) != 2'b11)
      |=> hist_at(hist_flat, $past(up_index)) == $past(hist_at(hist_flat, up_index)) + 2'd1);

   p_sat_hi_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (up_valid && up_taken && hist_at(hist_flat, up_index) == 2'b11)
      |=> hist_at(hist_flat, $past(up_index)) == 2'b11);

   p_dec_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (up_valid && !up_taken && hist_at(hist_flat, up_index) != 2'b00)
      |=> hist_at(hist_flat, $past(up_index)) == $past(hist_at(hist_flat, up_index)) - 2'd1);

   p_sat_lo_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (up_valid && !up_taken && hist_at(hist_flat, up_index) == 2'b00)
      |=> hist_at(hist_flat, $past(up_index)) == 2'b00);

   p_hint_r5: assert property (@(posedge clk) disable iff (!rst_n)
      lk_taken == hist_at(hist_flat, lk_idx)[1]);

   p_next_tk_r6: assert property (@(posedge clk) disable iff (!rst_n)
      lk_taken |-> lk_next_pc == lk_target);

   p_next_nt_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_taken |-> lk_next_pc == lk_pc + ADDR_W'(SEQ_STEP));

   p_tgt_wr_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (up_valid && up_taken) |=> tgt_at(tgt_flat, $past(up_index)) == $past(up_target));

   p_tgt_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (up_valid && !up_taken) |=> $stable(tgt_flat));

   p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !up_valid |=> ($stable(hist_flat) && $stable(tgt_flat)));

endmodule

bind branch_hint_table bht_checker #(
   .DEPTH     (DEPTH),
   .ADDR_W    (ADDR_W),
   .INDEX_LSB (INDEX_LSB),
   .SEQ_STEP  (SEQ_STEP)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .lk_pc      (lk_pc),
   .lk_taken   (lk_taken),
   .lk_target  (lk_target),
   .lk_next_pc (lk_next_pc),
   .up_valid   (up_valid),
   .up_index   (up_index),
   .up_taken   (up_taken),
   .up_target  (up_target),
   .hist_flat  (hist_flat),
   .tgt_flat   (tgt_flat)
);

// File: tb/test_branch_hint_table.sv
module test_branch_hint_table;

   localparam int DEPTH     = 16;
   localparam int ADDR_W    = 32;
   localparam int INDEX_LSB = 2;
   localparam int SEQ_STEP  = 4;
   localparam int IDX_W     = $clog2(DEPTH);

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [ADDR_W-1:0] lk_pc = '0;
   logic              lk_taken;
   logic [ADDR_W-1:0] lk_target;
   logic [ADDR_W-1:0] lk_next_pc;
   logic              up_valid = 1'b0;
   logic [IDX_W-1:0]  up_index = '0;
   logic              up_taken = 1'b0;
   logic [ADDR_W-1:0] up_target = '0;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   logic [1:0]        m_hist [DEPTH];
   logic [ADDR_W-1:0] m_tgt  [DEPTH];

   always #4 clk = ~clk;

   branch_hint_table #(
      .DEPTH     (DEPTH),
      .ADDR_W    (ADDR_W),
      .INDEX_LSB (INDEX_LSB),
      .SEQ_STEP  (SEQ_STEP)
   ) i_branch_hint_table (
      .clk        (clk),
      .rst_n      (rst_n),
      .lk_pc      (lk_pc),
      .lk_taken   (lk_taken),
      .lk_target  (lk_target),
      .lk_next_pc (lk_next_pc),
      .up_valid   (up_valid),
      .up_index   (up_index),
      .up_taken   (up_taken),
      .up_target  (up_target)
   );

   function automatic logic [1:0] model_step(logic [1:0] c, logic t);
      if (t) return (c == 2'b11) ? 2'b11 : c + 2'd1;
      return (c == 2'b00) ? 2'b00 : c - 2'd1;
   endfunction

   function automatic logic [ADDR_W-1:0] make_pc(logic [IDX_W-1:0] idx);
      logic [ADDR_W-1:0] p;
      p = ADDR_W'($urandom());
      p[INDEX_LSB +: IDX_W] = idx;
      return p;
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input logic [ADDR_W-1:0] act, input logic [ADDR_W-1:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic look_check(input string req);
      logic [IDX_W-1:0]  i;
      logic              e_tk;
      logic [ADDR_W-1:0] e_nx;
      i    = lk_pc[INDEX_LSB +: IDX_W];
      e_tk = m_hist[i][1];
      e_nx = e_tk ? m_tgt[i] : lk_pc + ADDR_W'(SEQ_STEP);
      check(lk_taken === e_tk, req, "taken hint", ADDR_W'(lk_taken), ADDR_W'(e_tk));
      check(lk_target === m_tgt[i], req, "stored target", lk_target, m_tgt[i]);
      check(lk_next_pc === e_nx, req, "next pc", lk_next_pc, e_nx);
   endtask

   // Drive at falling edge, check the lookup before the rising edge (old
   // contents, R8), then apply the update to the model after the edge.
   task automatic step(input logic [ADDR_W-1:0] pc, input logic v,
                       input logic [IDX_W-1:0] idx, input logic t,
                       input logic [ADDR_W-1:0] tg, input string req);
      @(negedge clk);
      lk_pc = pc; up_valid = v; up_index = idx; up_taken = t; up_target = tg;
      #1;
      look_check(req);
      @(posedge clk);
      if (v) begin
         m_hist[idx] = model_step(m_hist[idx], t);
         if (t) m_tgt[idx] = tg;
      end
   endtask

   task automatic idle_look(input logic [ADDR_W-1:0] pc, input string req);
      step(pc, 1'b0, '0, 1'b0, '0, req);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      for (int k = 0; k < DEPTH; k++) begin
         m_hist[k] = 2'b00;
         m_tgt[k]  = '0;
      end
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: reset contents on every slot
      for (int k = 0; k < DEPTH; k++) idle_look(make_pc(IDX_W'(k)), "R1");

      // R3 / R5: climb slot 3, hint flips at 10, saturate at 11
      step(make_pc(3), 1'b1, 4'd3, 1'b1, 32'h0000_1000, "R3");
      idle_look(make_pc(3), "R5");
      step(make_pc(3), 1'b1, 4'd3, 1'b1, 32'h0000_2000, "R3");
      idle_look(make_pc(3), "R5");
      step(make_pc(3), 1'b1, 4'd3, 1'b1, 32'h0000_3000, "R3");
      step(make_pc(3), 1'b1, 4'd3, 1'b1, 32'h0000_4000, "R3");
      idle_look(make_pc(3), "R6");

      // R7: not-taken keeps the stored address; R4 fall and saturate low
      step(make_pc(3), 1'b1, 4'd3, 1'b0, 32'hDEAD_BEE0, "R7");
      idle_look(make_pc(3), "R7");
      step(make_pc(3), 1'b1, 4'd3, 1'b0, 32'h0, "R4");
      idle_look(make_pc(3), "R5");
      for (int k = 0; k < 3; k++) step(make_pc(3), 1'b1, 4'd3, 1'b0, 32'h0, "R4");
      idle_look(make_pc(3), "R4");
      step(make_pc(3), 1'b1, 4'd3, 1'b1, 32'h0000_5000, "R4");
      idle_look(make_pc(3), "R4");

      // R2: aliasing addresses reach the same slot
      step(make_pc(5), 1'b1, 4'd5, 1'b1, 32'h0ABC_0000, "R2");
      step(make_pc(5), 1'b1, 4'd5, 1'b1, 32'h0ABC_0040, "R2");
      idle_look(32'hFFFF_FFD7, "R2");
      idle_look(32'h0000_0014, "R2");

      // R8: same-cycle update and lookup on one slot sees old contents
      step(make_pc(7), 1'b1, 4'd7, 1'b1, 32'h7000_0000, "R8");
      step(make_pc(7), 1'b1, 4'd7, 1'b1, 32'h7000_0100, "R8");
      step(make_pc(7), 1'b1, 4'd7, 1'b0, 32'h0, "R8");
      idle_look(make_pc(7), "R8");

      // R9: taken-looking stimulus with up_valid low changes nothing
      @(negedge clk);
      lk_pc = make_pc(9); up_valid = 1'b0; up_index = 4'd9; up_taken = 1'b1;
      up_target = 32'h9999_0000;
      @(posedge clk);
      @(posedge clk);
      idle_look(make_pc(9), "R9");

      // R10: neighbours of updated slots untouched
      for (int k = 0; k < DEPTH; k++) idle_look(make_pc(IDX_W'(k)), "R10");

      // random mix, collisions biased in
      for (int n = 0; n < 3000; n++) begin
         logic [IDX_W-1:0] ui;
         logic [IDX_W-1:0] li;
         ui = IDX_W'($urandom_range(0, DEPTH - 1));
         li = ($urandom_range(0, 3) == 0) ? ui : IDX_W'($urandom_range(0, DEPTH - 1));
         step(make_pc(li), ($urandom_range(0, 3) != 0), ui,
              ($urandom_range(0, 2) != 0), ADDR_W'($urandom()), "R10");
      end
      for (int k = 0; k < DEPTH; k++) idle_look(make_pc(IDX_W'(k)), "R10");

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule